// File: doc/BRIEF.md
# Overcurrent Limiter with Frequency Foldback

This block is the digital heart of a primary-side overcurrent loop for a switching converter. Two comparator flags arrive from the analog front end: one says the sensed current is above a moderate limit, the other says it is above a severe limit. A saturating integrator takes the place of the timing capacitor of an analog limiter. It charges slowly when the current is healthy. It discharges by an amount proportional to the overcurrent while the current is moderately high. It dumps quickly to a low floor when the current is severe.

Three controls are derived from the integrator for the PWM stage. The first is a duty-cycle ceiling, which is removed entirely once the integrator sits at its top clamp. The second is an oscillator period multiplier from 1 to 5; it only rises above 1 after the duty ceiling has already reached its minimum. The third is a drive-disable flag, raised while the severe limit is exceeded. When the overcurrent clears, the integrator simply climbs back. No restart sequence is triggered, so the converter never enters hiccup operation. Sensing, blanking and the PWM comparator itself live elsewhere.

Top module: `ocl_foldback_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the integrator holds its top value 4095, `duty_cap` is 242, `freq_div` is 1 and `drive_off` is 0.
- R2: With neither flag set, the integrator rises by 4 per clock edge and saturates at 4095. `duty_cap` equals 242 exactly when the integrator is at 4095.
- R3: With only `over_lo` set, the integrator falls by `excess_step` per edge and saturates at 0. A step of 0 leaves it unchanged.
- R4: With the integrator value I in 2048..4094, `duty_cap` = 8 + floor((I-2048)*234/2048). For I below 2048, `duty_cap` is 8.
- R5: `freq_div` = 1 + the number of k in 0..3 for which I < 2048-512*k. It is therefore 1 when I >= 2048, it climbs to 5 only for I < 512, and it never exceeds 5.
- R6: With `over_hi` set, `drive_off` is 1 after the next edge. On that edge the integrator drops by 1024 but not below 256, and it is raised to 256 if it was lower.
- R7: The edge after `over_hi` clears, `drive_off` returns to 0 and the integrator resumes from its present value. It can only grow by 4 per edge, with no jump back to a restart value.
- R8: When `over_lo` and `over_hi` are both set, the block behaves exactly as with `over_hi` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| over_lo | input | 1 | Sensed current above the moderate limit |
| over_hi | input | 1 | Sensed current above the severe limit |
| excess_step | input | 8 | Discharge amount per cycle, proportional to the overcurrent excess |
| duty_cap | output | 8 | Duty-cycle ceiling in 1/256 units |
| freq_div | output | 3 | Oscillator period multiplier, 1 to 5 |
| drive_off | output | 1 | Disable both primary drivers |

## Verification
Several rules hold on every cycle and are checked there: the divider stays within 1..5, folding only happens with the duty ceiling already at its minimum, the disable flag follows the severe flag one edge later, the integrator never sinks below the floor after a severe cycle, and it never rises by more than one charge step outside a severe cycle. The exact values are shown only by the bench's scenarios: the linear duty ramp across the upper range, the band edges of the divider, saturation at both ends, the four-step dump from the top with the clamp on the last step, and the recovery climb after the severe flag clears.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

   typedef enum logic [1:0] {
      OCL_CHARGE = 2'd0,
      OCL_TRIM   = 2'd1,
      OCL_SEVERE = 2'd2
   } ocl_region_e;

   function automatic ocl_region_e ocl_pick_region(input logic lo_flag, input logic hi_flag);
      if (hi_flag)      return OCL_SEVERE;
      else if (lo_flag) return OCL_TRIM;
      else              return OCL_CHARGE;
   endfunction

endpackage

// File: rtl/ocl_region_sel.sv
module ocl_region_sel
   import ocl_pkg::*;
(
   input  logic        over_lo,
   input  logic        over_hi,
   output ocl_region_e region
);

   // severe limit outranks the moderate one (R8)
   always_comb begin
      region = ocl_pick_region(over_lo, over_hi);
   end

endmodule

// File: rtl/ocl_integrator.sv
module ocl_integrator
   import ocl_pkg::*;
#(
   parameter int INT_W       = 12,
   parameter int STEP_W      = 8,
   parameter int CHARGE_STEP = 4,
   parameter int DUMP_STEP   = 1024,
   parameter int INT_LO      = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ocl_region_e       region,
   input  logic [STEP_W-1:0] step,
   output logic [INT_W-1:0]  acc
);

   localparam int XW     = INT_W + 1;
   localparam int INT_HI = (1 << INT_W) - 1;
   localparam logic [XW-1:0] K_HI   = XW'(INT_HI);
   localparam logic [XW-1:0] K_LO   = XW'(INT_LO);
   localparam logic [XW-1:0] K_CHG  = XW'(CHARGE_STEP);
   localparam logic [XW-1:0] K_DUMP = XW'(DUMP_STEP);

   if (STEP_W > INT_W) begin : g_bad_step
      $error("ocl_integrator: STEP_W wider than INT_W");
   end
   if (INT_LO <= 0 || INT_LO >= INT_HI) begin : g_bad_lo
      $error("ocl_integrator: INT_LO out of range");
   end
   if (CHARGE_STEP <= 0 || DUMP_STEP <= 0) begin : g_bad_rates
      $error("ocl_integrator: rates must be positive");
   end

   logic [XW-1:0]    acc_x;
   logic [XW-1:0]    step_x;
   logic [XW-1:0]    rise_x;
   logic [INT_W-1:0] acc_nxt;

   always_comb begin
      acc_x  = {1'b0, acc};
      step_x = {{(XW-STEP_W){1'b0}}, step};
      rise_x = acc_x + K_CHG;
      unique case (region)
         OCL_CHARGE: begin
            if (rise_x >= K_HI) acc_nxt = INT_W'(INT_HI);
            else                acc_nxt = rise_x[INT_W-1:0];
         end
         OCL_TRIM: begin
            if (acc_x >= step_x) acc_nxt = INT_W'(acc_x - step_x);
            else                 acc_nxt = '0;
         end
         OCL_SEVERE: begin
            if (acc_x <= K_LO)                acc_nxt = INT_W'(INT_LO);
            else if (acc_x - K_LO <= K_DUMP)  acc_nxt = INT_W'(INT_LO);
            else                              acc_nxt = INT_W'(acc_x - K_DUMP);
         end
         default: acc_nxt = acc;
      endcase
   end

   // R1: reset parks the integrator at its top clamp
   always_ff @(posedge clk) begin
      if (!rst_n) acc <= INT_W'(INT_HI);
      else        acc <= acc_nxt;
   end

   // R2: idle cycles climb by one charge step unless at the clamp
   a_r2_charge_step: assert property (@(posedge clk) disable iff (!rst_n)
      (region == OCL_CHARGE && int'(acc) + CHARGE_STEP < INT_HI)
      |=> (int'(acc) == int'($past(acc)) + CHARGE_STEP));

   // R3: a moderate cycle never raises the integrator
   a_r3_trim_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (region == OCL_TRIM) |=> (acc <= $past(acc)));

   // R6: a severe cycle leaves the integrator at or above the floor
   a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (region == OCL_SEVERE) |=> (int'(acc) >= INT_LO));

   // R7: outside a severe cycle the rise per edge is bounded by the charge step
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (region != OCL_SEVERE) |=> (int'(acc) <= int'($past(acc)) + CHARGE_STEP));

endmodule

// File: rtl/ocl_duty_map.sv
module ocl_duty_map #(
   parameter int INT_W    = 12,
   parameter int DUTY_W   = 8,
   parameter int DUTY_MAX = 242,
   parameter int DUTY_MIN = 8
) (
   input  logic [INT_W-1:0]  acc,
   output logic [DUTY_W-1:0] duty
);

   localparam int INT_HI = (1 << INT_W) - 1;
   localparam int SPAN   = INT_W - 1;
   localparam int RANGE  = DUTY_MAX - DUTY_MIN;
   localparam int PW     = SPAN + DUTY_W;

   if (DUTY_MIN < 0 || DUTY_MIN > DUTY_MAX) begin : g_bad_order
      $error("ocl_duty_map: DUTY_MIN above DUTY_MAX");
   end
   if (DUTY_MAX >= (1 << DUTY_W)) begin : g_bad_max
      $error("ocl_duty_map: DUTY_MAX does not fit DUTY_W");
   end

   logic [DUTY_W-1:0] ramp;

   if (RANGE == 0) begin : g_flat
      assign ramp = DUTY_W'(DUTY_MIN);
   end else begin : g_lin
      logic [PW-1:0] prod;
      // offset above the knee is simply the low bits when the top bit is set
      assign prod = {{DUTY_W{1'b0}}, acc[SPAN-1:0]} * PW'(RANGE);
      assign ramp = DUTY_W'(DUTY_MIN) + DUTY_W'(prod >> SPAN);
   end

   // R4: full ceiling at the clamp, linear over the upper half, floor below
   always_comb begin
      if (int'(acc) == INT_HI)  duty = DUTY_W'(DUTY_MAX);
      else if (acc[INT_W-1])    duty = ramp;
      else                      duty = DUTY_W'(DUTY_MIN);
   end

endmodule

// File: rtl/ocl_fold_map.sv
module ocl_fold_map #(
   parameter int INT_W      = 12,
   parameter int FOLD_MAX   = 5,
   parameter int BAND_SHIFT = 9,
   parameter int DIV_W      = 3
) (
   input  logic [INT_W-1:0] acc,
   output logic [DIV_W-1:0] div
);

   localparam int KNEE  = 1 << (INT_W - 1);
   localparam int BAND  = 1 << BAND_SHIFT;
   localparam int NCMP  = FOLD_MAX - 1;

   if (FOLD_MAX < 2) begin : g_bad_fold
      $error("ocl_fold_map: FOLD_MAX must be at least 2");
   end
   if (KNEE - (NCMP - 1) * BAND <= 0) begin : g_bad_band
      $error("ocl_fold_map: bands do not fit below the knee");
   end
   if (FOLD_MAX >= (1 << DIV_W)) begin : g_bad_divw
      $error("ocl_fold_map: DIV_W too narrow");
   end

   logic [NCMP-1:0] below;

   // R5: one comparator per band edge, counted into the divisor
   for (genvar k = 0; k < NCMP; k++) begin : g_band
      assign below[k] = (int'(acc) < KNEE - k * BAND);
   end

   assign div = DIV_W'(1 + $countones(below));

endmodule

// File: rtl/ocl_foldback_ctrl.sv
module ocl_foldback_ctrl
   import ocl_pkg::*;
#(
   parameter int INT_W       = 12,
   parameter int STEP_W      = 8,
   parameter int DUTY_W      = 8,
   parameter int DUTY_MAX    = 242,
   parameter int DUTY_MIN    = 8,
   parameter int CHARGE_STEP = 4,
   parameter int DUMP_STEP   = 1024,
   parameter int INT_LO      = 256,
   parameter int FOLD_MAX    = 5,
   parameter int BAND_SHIFT  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              over_lo,
   input  logic              over_hi,
   input  logic [STEP_W-1:0] excess_step,
   output logic [DUTY_W-1:0] duty_cap,
   output logic [2:0]        freq_div,
   output logic              drive_off
);

   localparam int DIV_W = 3;
   localparam int KNEE  = 1 << (INT_W - 1);

   if (INT_W < 4) begin : g_bad_intw
      $error("ocl_foldback_ctrl: INT_W too small");
   end
   if (INT_LO >= KNEE) begin : g_bad_floor
      $error("ocl_foldback_ctrl: floor must sit below the knee");
   end

   ocl_region_e      region;
   logic [INT_W-1:0] acc;

   ocl_region_sel u_sel (
      .over_lo (over_lo),
      .over_hi (over_hi),
      .region  (region)
   );

   ocl_integrator #(
      .INT_W       (INT_W),
      .STEP_W      (STEP_W),
      .CHARGE_STEP (CHARGE_STEP),
      .DUMP_STEP   (DUMP_STEP),
      .INT_LO      (INT_LO)
   ) u_int (
      .clk    (clk),
      .rst_n  (rst_n),
      .region (region),
      .step   (excess_step),
      .acc    (acc)
   );

   ocl_duty_map #(
      .INT_W    (INT_W),
      .DUTY_W   (DUTY_W),
      .DUTY_MAX (DUTY_MAX),
      .DUTY_MIN (DUTY_MIN)
   ) u_duty (
      .acc  (acc),
      .duty (duty_cap)
   );

   ocl_fold_map #(
      .INT_W      (INT_W),
      .FOLD_MAX   (FOLD_MAX),
      .BAND_SHIFT (BAND_SHIFT),
      .DIV_W      (DIV_W)
   ) u_fold (
      .acc (acc),
      .div (freq_div)
   );

   // R6 / R7: drivers stay off exactly while the severe limit was seen
   always_ff @(posedge clk) begin
      if (!rst_n) drive_off <= 1'b0;
      else        drive_off <= (region == OCL_SEVERE);
   end

   // R6: severe flag gates the drivers on the next edge
   a_r6_off_next: assert property (@(posedge clk) disable iff (!rst_n)
      over_hi |=> drive_off);

   // R7: drivers come back on the edge after the severe flag clears
   a_r7_on_next: assert property (@(posedge clk) disable iff (!rst_n)
      !over_hi |=> !drive_off);

   // R8: both flags together behave as the severe case
   a_r8_both_severe: assert property (@(posedge clk) disable iff (!rst_n)
      (over_hi && over_lo) |=> (drive_off && int'(acc) >= INT_LO));

   // R5: divisor stays inside its legal window
   a_r5_div_window: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_div >= 3'd1 && int'(freq_div) <= FOLD_MAX));

   // R5: folding only begins once the ceiling is at its minimum
   a_r5_trim_first: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_div != 3'd1) |-> (int'(duty_cap) == DUTY_MIN));

   // R4: ceiling stays between its bounds
   a_r4_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(duty_cap) >= DUTY_MIN && int'(duty_cap) <= DUTY_MAX));

endmodule

// File: tb/ocl_foldback_ctrl_bench.sv
module ocl_foldback_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       over_lo = 1'b0;
   logic       over_hi = 1'b0;
   logic [7:0] excess_step = 8'd0;
   logic [7:0] duty_cap;
   logic [2:0] freq_div;
   logic       drive_off;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int m_acc = 4095;
   bit m_off = 1'b0;

   always #2.5 clk = ~clk;

   ocl_foldback_ctrl u_ocl_foldback_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .over_lo     (over_lo),
      .over_hi     (over_hi),
      .excess_step (excess_step),
      .duty_cap    (duty_cap),
      .freq_div    (freq_div),
      .drive_off   (drive_off)
   );

   function automatic int exp_duty(input int a);
      if (a == 4095) return 242;
      if (a >= 2048) return 8 + (((a - 2048) * 234) >> 11);
      return 8;
   endfunction

   function automatic int exp_div(input int a);
      int d = 1;
      for (int k = 0; k < 4; k++) if (a < 2048 - 512 * k) d++;
      return d;
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", what, act, expv);
      end
   endtask

   task automatic check_outs(input string tag);
      check(int'(duty_cap) == exp_duty(m_acc), {tag, " duty_cap R4"}, int'(duty_cap), exp_duty(m_acc));
      check(int'(freq_div) == exp_div(m_acc), {tag, " freq_div R5"}, int'(freq_div), exp_div(m_acc));
      check(drive_off == m_off, {tag, " drive_off R6"}, int'(drive_off), int'(m_off));
   endtask

   // drive at a falling edge, let one rising edge pass, check at the next falling edge
   task automatic run1(input bit lo, input bit hi, input int st, input string tag);
      over_lo = lo;
      over_hi = hi;
      excess_step = 8'(st);
      @(posedge clk);
      if (hi) begin
         if (m_acc <= 256 || m_acc - 256 <= 1024) m_acc = 256;
         else m_acc = m_acc - 1024;
      end else if (lo) begin
         m_acc = (m_acc >= st) ? m_acc - st : 0;
      end else begin
         m_acc = (m_acc + 4 >= 4095) ? 4095 : m_acc + 4;
      end
      m_off = hi;
      @(negedge clk);
      check_outs(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C1F_0BAC));
      repeat (3) @(negedge clk);
      // R1: reset values
      m_acc = 4095;
      m_off = 1'b0;
      check_outs("R1 in reset");
      check(int'(duty_cap) == 242, "R1 duty_cap at reset", int'(duty_cap), 242);
      rst_n = 1'b1;
      // R2: idle at the clamp keeps full ceiling
      for (int i = 0; i < 5; i++) run1(1'b0, 1'b0, 0, "R2 idle at clamp");
      check(int'(duty_cap) == 242, "R2 full ceiling held", int'(duty_cap), 242);
      // R3: moderate trim ramps the ceiling down, then folds
      for (int i = 0; i < 25; i++) run1(1'b1, 1'b0, 100, "R3 trim step 100");
      check(int'(freq_div) == 2, "R3 first fold band", int'(freq_div), 2);
      for (int i = 0; i < 4; i++) run1(1'b1, 1'b0, 0, "R3 zero step holds");
      for (int i = 0; i < 10; i++) run1(1'b1, 1'b0, 255, "R3 drain to zero");
      check(int'(freq_div) == 5, "R3 deepest fold at zero", int'(freq_div), 5);
      // R6: severe from empty clamps up to floor
      run1(1'b0, 1'b1, 0, "R6 severe from empty");
      check(drive_off == 1'b1, "R6 drivers off", int'(drive_off), 1);
      // R7: release climbs from the floor
      for (int i = 0; i < 600; i++) run1(1'b0, 1'b0, 0, "R7 recovery climb");
      check(drive_off == 1'b0, "R7 drivers back on", int'(drive_off), 0);
      // R2: saturate at the top
      for (int i = 0; i < 1000; i++) run1(1'b0, 1'b0, 0, "R2 recharge to clamp");
      check(int'(duty_cap) == 242, "R2 saturated ceiling", int'(duty_cap), 242);
      // R8: both flags from the top dump in four steps, last one clamped
      for (int i = 0; i < 5; i++) run1(1'b1, 1'b1, 37, "R8 both flags dump");
      check(int'(freq_div) == 5 && drive_off, "R8 floor and off", int'(freq_div), 5);
      run1(1'b1, 1'b0, 10, "R7 exit severe into trim");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r = $urandom_range(0, 19);
         int st = $urandom_range(0, 255);
         if (r < 2)       run1(1'($urandom_range(0, 1)), 1'b1, st, "rand severe R6");
         else if (r < 9)  run1(1'b1, 1'b0, st, "rand trim R3");
         else             run1(1'b0, 1'b0, st, "rand idle R2");
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule